// File: doc/BRIEF.md
# Timer Slave-Mode Trigger Controller

This block is an up-counter with a programmable reload value whose behaviour toward an external trigger line is picked at run time by a 3-bit mode code. Depending on the code, the trigger is ignored, restarts the count, gates counting by its level, starts a stopped counter, or replaces the internal clock so that each of its rising edges adds one. Encoder codes are accepted but freeze the counter.

The trigger line is asynchronous. It passes through a two-stage synchronizer and then a rising-edge detector. In every mode whose top code bit is 1, a detected edge sets a sticky trigger flag. A one-cycle strobe clears the flag. The flag drives an interrupt request and a DMA request, and each of the two is qualified by its own enable input.

All pins are plain control and status signals. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `tmr_slave_top`

## Requirements
- R1: With mode 3'b000 and `sw_en_i`=1, `cnt_o` advances by one on every clock. With `sw_en_i`=0, it holds. Activity on `trig_i` never changes the count in this mode.
- R2: On an advancing cycle where `cnt_o` equals `reload_i`, the counter loads 0 and `ovf_o` is 1 for exactly that one following cycle. Otherwise `ovf_o` is 0.
- R3: With mode 3'b100, a detected trigger edge loads 0 into the counter. This restart takes priority over advancing and leaves `ovf_o` at 0.
- R4: With mode 3'b101 and the counter enabled, the counter advances only while the synchronized trigger level is 1. It holds while that level is 0.
- R5: With mode 3'b110, a detected trigger edge enables a stopped counter, which first increments on the following clock. The counter stays enabled until the mode changes.
- R6: With mode 3'b111 and the counter enabled, each rising edge of `trig_i` advances the counter by exactly one, and cycles with no edge hold it. With `sw_en_i`=0, edges are ignored.
- R7: Codes 3'b001, 3'b010 and 3'b011 hold the counter unchanged whatever `trig_i` does.
- R8: A rising edge on `trig_i` takes effect at the third rising clock edge after it (two synchronizer stages, then the edge-detect register).
- R9: `trig_flag_o` is set by a detected edge in modes 3'b100 to 3'b111, is never set in modes 3'b000 to 3'b011, and is cleared by `flag_clr_i`. When a set and a clear arrive together, the set wins.
- R10: `irq_o` equals `trig_flag_o` AND `trig_ie_i`, and `dma_o` equals `trig_flag_o` AND `trig_de_i`, with no added delay.
- R11: While `rst_ni` is 0, `cnt_o`, `ovf_o`, `trig_flag_o`, `irq_o` and `dma_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Asynchronous external trigger |
| mode_i | input | 3 | Slave mode code |
| sw_en_i | input | 1 | Software counter enable |
| reload_i | input | CNT_W | Reload (wrap) value |
| trig_ie_i | input | 1 | Trigger interrupt enable |
| trig_de_i | input | 1 | Trigger DMA enable |
| flag_clr_i | input | 1 | One-cycle clear strobe for the trigger flag |
| cnt_o | output | CNT_W | Counter value |
| ovf_o | output | 1 | One-cycle overflow pulse |
| trig_flag_o | output | 1 | Sticky trigger flag |
| irq_o | output | 1 | Trigger interrupt request |
| dma_o | output | 1 | Trigger DMA request |

## Verification
Changes to the inputs that are sampled directly (`sw_en_i`, `mode_i`, `flag_clr_i`) act on the next rising clock edge. `cnt_o` and `ovf_o` therefore move one clock later. A trigger edge acts on the third rising clock edge, and the trigger level seen by gating mode also lags by two clocks. `irq_o` and `dma_o` follow the flag and the enables within the same cycle. The bench changes inputs and samples outputs on falling edges, and counts the exact number of falling edges between a stimulus and its check. It also checks one edge before the trigger's due cycle, to show the trigger has not acted early.

// File: rtl/tmr_slv_pkg.sv
package tmr_slv_pkg;
  typedef enum logic [2:0] {
    SM_OFF     = 3'b000,
    SM_ENC_A   = 3'b001,
    SM_ENC_B   = 3'b010,
    SM_ENC_C   = 3'b011,
    SM_RESTART = 3'b100,
    SM_GATE    = 3'b101,
    SM_START   = 3'b110,
    SM_EXTCLK  = 3'b111
  } slv_mode_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= trig_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], trig_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sh_q[STAGES-1];
  end

  assign level_o = sh_q[STAGES-1];
  assign edge_o  = sh_q[STAGES-1] & ~prev_q;

  // R8
  edge_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/slave_ctl.sv
module slave_ctl
  import tmr_slv_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  slv_mode_e mode_i,
  input  logic      sw_en_i,
  input  logic      level_i,
  input  logic      edge_i,
  output logic      adv_o,
  output logic      restart_o,
  output logic      flag_set_o
);
  logic started_q;
  logic run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                started_q <= 1'b0;
    else if (mode_i != SM_START) started_q <= 1'b0;
    else if (edge_i)            started_q <= 1'b1;
  end

  assign run = sw_en_i | started_q;

  always_comb begin
    unique case (mode_i)
      SM_OFF, SM_RESTART, SM_START: adv_o = run;
      SM_GATE:                      adv_o = run & level_i;
      SM_EXTCLK:                    adv_o = run & edge_i;
      default:                      adv_o = 1'b0;
    endcase
  end

  assign restart_o  = (mode_i == SM_RESTART) & edge_i;
  assign flag_set_o = mode_i[2] & edge_i;

  // R5
  start_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SM_START && edge_i) |=> (started_q || mode_i != SM_START));
endmodule

// File: rtl/cnt_core.sv
module cnt_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (adv_i) begin
      if (cnt_q == reload_i) begin
        cnt_q <= '0;
        ovf_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        ovf_q <= 1'b0;
      end
    end else begin
      ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R3
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0 && !ovf_q));
  // R2
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !restart_i && cnt_q == reload_i) |=> (cnt_q == '0 && ovf_q));
  // R1
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !restart_i) |=> ($stable(cnt_q) && !ovf_q));
endmodule

// File: rtl/trig_flag.sv
module trig_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  input  logic de_i,
  output logic flag_o,
  output logic irq_o,
  output logic dma_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i;
  assign dma_o  = flag_q & de_i;

  // R9
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  // R9
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/tmr_slave_top.sv
module tmr_slave_top
  import tmr_slv_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [2:0]       mode_i,
  input  logic             sw_en_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             trig_ie_i,
  input  logic             trig_de_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             trig_flag_o,
  output logic             irq_o,
  output logic             dma_o
);
  slv_mode_e mode;
  logic      level, edge_det, adv, restart, flag_set;

  assign mode = slv_mode_e'(mode_i);

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i),
    .level_o(level), .edge_o(edge_det)
  );

  slave_ctl u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .sw_en_i(sw_en_i),
    .level_i(level), .edge_i(edge_det),
    .adv_o(adv), .restart_o(restart), .flag_set_o(flag_set)
  );

  cnt_core #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .restart_i(restart),
    .reload_i(reload_i), .cnt_o(cnt_o), .ovf_o(ovf_o)
  );

  trig_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(flag_set), .clr_i(flag_clr_i),
    .ie_i(trig_ie_i), .de_i(trig_de_i),
    .flag_o(trig_flag_o), .irq_o(irq_o), .dma_o(dma_o)
  );

  // R7
  reserved_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i inside {3'b001, 3'b010, 3'b011}) |=> $stable(cnt_o));
endmodule

// File: tb/tb_tmr_slave_top.sv
module tb_tmr_slave_top;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig = 1'b0;
  logic [2:0]    mode = 3'b000;
  logic          sw_en = 1'b0;
  logic [CW-1:0] reload = '0;
  logic          ie = 1'b0, de = 1'b0, clr = 1'b0;
  logic [CW-1:0] cnt;
  logic          ovf, flag, irq, dma;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tmr_slave_top #(.CNT_W(CW), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .mode_i(mode),
    .sw_en_i(sw_en), .reload_i(reload), .trig_ie_i(ie), .trig_de_i(de),
    .flag_clr_i(clr), .cnt_o(cnt), .ovf_o(ovf), .trig_flag_o(flag),
    .irq_o(irq), .dma_o(dma)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    trig = 1'b0; sw_en = 1'b0; clr = 1'b0; mode = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c;
    int ovf_seen;
    // R11: reset state, enables high to expose the request lines
    ie = 1'b1; de = 1'b1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 cnt", cnt, 0);
    chk("R11 ovf", ovf, 0);
    chk("R11 flag", flag, 0);
    chk("R11 irq", irq, 0);
    chk("R11 dma", dma, 0);
    do_reset();

    // R1/R2: free count in mode 000 with the trigger toggling
    reload = 4'd5; sw_en = 1'b1;
    for (int k = 1; k <= 14; k++) begin
      trig = k[0];
      @(negedge clk);
      chk("R1 count", cnt, k % 6);
      chk("R2 ovf", ovf, (k % 6 == 0) ? 1 : 0);
    end
    trig = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 no flag in off mode", flag, 0);
    sw_en = 1'b0;
    @(negedge clk);
    c = cnt;
    repeat (4) @(negedge clk);
    chk("R1 disabled hold", cnt, c);

    // R7: reserved codes freeze the counter
    sw_en = 1'b1;
    for (int m = 1; m <= 3; m++) begin
      mode = m[2:0];
      c = cnt;
      for (int j = 0; j < 6; j++) begin
        trig = j[0];
        @(negedge clk);
      end
      chk("R7 reserved hold", cnt, c);
      chk("R9 no flag reserved", flag, 0);
    end
    trig = 1'b0;

    // R3/R8: restart mode
    do_reset();
    mode = 3'b100; reload = 4'd15; sw_en = 1'b1;
    repeat (5) @(negedge clk);
    trig = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 not yet", cnt, 7);
    @(negedge clk);
    chk("R3 restart cnt", cnt, 0);
    chk("R3 no ovf", ovf, 0);
    chk("R9 flag set", flag, 1);
    @(negedge clk);
    chk("R3 resume", cnt, 1);
    trig = 1'b0;
    repeat (3) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R9 flag clear", flag, 0);
    // R9: set wins over clear in the same cycle
    trig = 1'b1;
    repeat (2) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R9 set wins", flag, 1);
    chk("R3 second restart", cnt, 0);
    trig = 1'b0;

    // R10: request gating
    for (int v = 0; v < 4; v++) begin
      ie = v[0]; de = v[1];
      #1;
      chk("R10 irq", irq, v & 1);
      chk("R10 dma", dma, (v >> 1) & 1);
    end
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; ie = 1'b1; de = 1'b1;
    #1;
    chk("R10 irq flag low", irq, 0);
    chk("R10 dma flag low", dma, 0);

    // R5: trigger start mode
    do_reset();
    mode = 3'b110; reload = 4'd15; sw_en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 stopped", cnt, 0);
    trig = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 start edge", cnt, 0);
    @(negedge clk);
    chk("R5 first inc", cnt, 1);
    @(negedge clk);
    chk("R5 second inc", cnt, 2);
    trig = 1'b0;

    // R4: gated mode
    do_reset();
    mode = 3'b101; reload = 4'd15; sw_en = 1'b1;
    repeat (6) @(negedge clk);
    chk("R4 low hold", cnt, 0);
    trig = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      c = cnt;
      @(negedge clk);
      chk("R4 high advance", cnt, (c + 1) % 16);
    end
    trig = 1'b0;
    repeat (3) @(negedge clk);
    c = cnt;
    repeat (5) @(negedge clk);
    chk("R4 low again hold", cnt, c);

    // R6/R2: trigger as count clock
    do_reset();
    mode = 3'b111; reload = 4'd3; sw_en = 1'b1;
    ovf_seen = 0;
    for (int p = 1; p <= 9; p++) begin
      trig = 1'b1;
      repeat (3) begin @(negedge clk); if (ovf) ovf_seen++; end
      trig = 1'b0;
      repeat (3) begin @(negedge clk); if (ovf) ovf_seen++; end
      chk("R6 edge count", cnt, p % 4);
    end
    chk("R2 ovf pulses", ovf_seen, 2);
    sw_en = 1'b0;
    c = cnt;
    trig = 1'b1;
    repeat (3) @(negedge clk);
    trig = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 disabled ignore", cnt, c);

    finish_run();
  end
endmodule